// File: doc/BRIEF.md
# Alarm Annunciation Controller

The controller folds six condition inputs into a single annunciation state: a latched alarm, a general fault, a trouble warning, a loss of sensing, a command/proof disagreement, and a request for a lamp and sounder test. Each state drives the four indicator LEDs (power, alarm, fault, comm) and a sounder enable with a fixed pattern. The patterns are stepped by a phase counter that advances on an external tick, so one frame spans `PHASE_LEN` ticks. Each state also produces its own event code.

Silence and reset arrive as single-cycle request pulses. Silence mutes the sounder only. Reset clears the latched alarm and the test run, and the conditions are then classified again from the live inputs. Every state change, silence request and reset request emits a one-cycle event strobe with a code. When several events are due in the same cycle, a small arbiter serialises them in a fixed order so that none is lost.

Top module: `annun_ctrl`

## Requirements
- R1: After reset the block is in the Normal state: power and comm LEDs lit, alarm and fault LEDs dark, sounder off, and no event strobe. On the first cycle after reset is released it emits event code 0x00 (heartbeat/OK).
- R2: The state is chosen in this priority order: sensing lost, then proof mismatch, then latched alarm, then general fault, then trouble, then Normal. Sensing loss and proof mismatch both give Fault, with codes 0x21 and 0x22 respectively. A general fault gives Fault with code 0x23, but only when no alarm is latched. Alarm is code 0x10 and Trouble is code 0x30.
- R3: An alarm input pulse latches the Alarm state. Alarm stays latched after the input drops and until a reset request.
- R4: A silence request forces the sounder off and leaves the state and the LEDs unchanged. The mute ends when the state changes or when a reset request arrives. If a state change or a reset falls in the same cycle as the silence request, the sounder is not muted.
- R5: With phase p in a frame of PHASE_LEN ticks (Q = PHASE_LEN/4), the sounder pattern depends on the state. Alarm sounds on even p below 2Q. Fault sounds on every p below 2Q. Trouble and Test sound only at p = 0. Normal never sounds. The sounder is never on for p at or above 2Q, so its duty stays at or below 50%. The phase restarts at 0 on every state change.
- R6: The LEDs follow the state. Power is lit in every state except Test. Comm is lit except in Trouble, where it is lit only for p below 2Q. The alarm LED is lit only in Alarm, for (p mod 2Q) < Q. The fault LED is lit steadily in Fault.
- R7: A test request is acted on only in the Normal state, and it enters Test (code 0x40). In Test exactly one LED is lit, chosen by p/Q: power, then alarm, then fault, then comm. Test ends after TEST_TICKS ticks, or at once when any condition appears, and the block then takes the classified state.
- R8: At most one event is emitted per cycle. A pending reset event (0x60) goes first, then a pending silence event (0x50), then a state event. Every request is logged exactly once, one cycle after it arrives unless an event ahead of it takes that slot.
- R9: A reset request forces Normal in the following cycle, clears the mute, and marks the current state as not yet reported. If a condition is still present, its state is re-entered one cycle later and reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Pattern time base pulse, one cycle wide |
| alarm_in | input | 1 | Alarm condition (latched internally) |
| fault_in | input | 1 | General fault condition |
| trouble_in | input | 1 | Trouble / degraded supervision condition |
| proof_mismatch | input | 1 | Observed output disagrees with command |
| sensing_lost | input | 1 | Input sensing can no longer be trusted |
| test_req | input | 1 | Test request pulse |
| silence_req | input | 1 | Silence request pulse |
| reset_req | input | 1 | Reset request pulse |
| led_pwr | output | 1 | Power LED |
| led_alm | output | 1 | Alarm LED |
| led_flt | output | 1 | Fault LED |
| led_comm | output | 1 | Comm LED |
| buzzer_en | output | 1 | Sounder enable |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 8 | Event code, valid with evt_valid |

## Verification
The delicate case is a silence or reset request that lands in the same cycle as a state transition. Two things are decided in that cycle: whether the mute survives, and how the two resulting events are ordered. The bench drives a silence pulse on the same edge as an alarm rising. It expects the sounder to be audible in the new state and the silence event to come out before the Alarm event. It then drives reset, silence and a held alarm together. It expects a Normal cycle, then the Alarm state re-entered with the sounder on, and then the reset, silence and Alarm events in that order on consecutive cycles.

// File: rtl/annun_pkg.sv
package annun_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_ALARM   = 3'd1,
    ST_FAULT   = 3'd2,
    ST_TROUBLE = 3'd3,
    ST_TEST    = 3'd4
  } ann_state_e;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] EC_OK        = 8'h00;
  localparam logic [CODE_W-1:0] EC_ALARM     = 8'h10;
  localparam logic [CODE_W-1:0] EC_FLT_SENSE = 8'h21;
  localparam logic [CODE_W-1:0] EC_FLT_PROOF = 8'h22;
  localparam logic [CODE_W-1:0] EC_FLT_GEN   = 8'h23;
  localparam logic [CODE_W-1:0] EC_TROUBLE   = 8'h30;
  localparam logic [CODE_W-1:0] EC_TEST      = 8'h40;
  localparam logic [CODE_W-1:0] EC_SILENCE   = 8'h50;
  localparam logic [CODE_W-1:0] EC_RESET     = 8'h60;
  localparam logic [CODE_W-1:0] EC_NONE      = 8'hFF;

  typedef struct packed {
    logic pwr;
    logic alm;
    logic flt;
    logic comm;
  } led_t;

  // LED code for a state at phase ph of a frame of 4*qtr ticks
  function automatic led_t pat_leds(ann_state_e st, logic [31:0] ph, logic [31:0] qtr);
    led_t l;
    l.pwr  = 1'b1;
    l.alm  = 1'b0;
    l.flt  = 1'b0;
    l.comm = 1'b1;
    case (st)
      ST_ALARM:   l.alm  = (ph % (2 * qtr)) < qtr;
      ST_FAULT:   l.flt  = 1'b1;
      ST_TROUBLE: l.comm = ph < (2 * qtr);
      ST_TEST: begin
        l = '0;
        case (ph / qtr)
          32'd0:   l.pwr  = 1'b1;
          32'd1:   l.alm  = 1'b1;
          32'd2:   l.flt  = 1'b1;
          default: l.comm = 1'b1;
        endcase
      end
      default: ;
    endcase
    return l;
  endfunction

  // Sounder cadence; every pattern lies in the first half frame
  function automatic logic pat_buzz(ann_state_e st, logic [31:0] ph, logic [31:0] qtr);
    logic b;
    case (st)
      ST_ALARM:   b = (ph < (2 * qtr)) && (ph[0] == 1'b0);
      ST_FAULT:   b = ph < (2 * qtr);
      ST_TROUBLE: b = ph == 32'd0;
      ST_TEST:    b = ph == 32'd0;
      default:    b = 1'b0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/annun_classify.sv
module annun_classify
  import annun_pkg::*;
(
  input  logic                sensing_lost,
  input  logic                proof_mismatch,
  input  logic                alarm_eff,
  input  logic                fault_in,
  input  logic                trouble_in,
  output ann_state_e          base_state,
  output logic [CODE_W-1:0]   base_code
);

  always_comb begin
    if (sensing_lost) begin
      base_state = ST_FAULT;
      base_code  = EC_FLT_SENSE;
    end else if (proof_mismatch) begin
      base_state = ST_FAULT;
      base_code  = EC_FLT_PROOF;
    end else if (alarm_eff) begin
      base_state = ST_ALARM;
      base_code  = EC_ALARM;
    end else if (fault_in) begin
      base_state = ST_FAULT;
      base_code  = EC_FLT_GEN;
    end else if (trouble_in) begin
      base_state = ST_TROUBLE;
      base_code  = EC_TROUBLE;
    end else begin
      base_state = ST_NORMAL;
      base_code  = EC_OK;
    end
  end

endmodule

// File: rtl/annun_pattern.sv
module annun_pattern
  import annun_pkg::*;
#(
  parameter int PHASE_LEN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          restart,
  input  ann_state_e                    state,
  input  logic                          silenced,
  output led_t                          leds,
  output logic                          buzz,
  output logic [$clog2(PHASE_LEN)-1:0]  phase
);

  localparam int PH_W = $clog2(PHASE_LEN);
  localparam logic [31:0] QTR = 32'(PHASE_LEN / 4);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= (phase_q == PH_W'(PHASE_LEN - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase = phase_q;
  assign leds  = pat_leds(state, 32'(phase_q), QTR);
  assign buzz  = pat_buzz(state, 32'(phase_q), QTR) & ~silenced;

endmodule

// File: rtl/annun_evlog.sv
module annun_evlog
  import annun_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                silence_req,
  input  logic                reset_req,
  input  logic [CODE_W-1:0]   cur_code,
  output logic                evt_valid,
  output logic [CODE_W-1:0]   evt_code
);

  logic              pend_rst_q;
  logic              pend_sil_q;
  logic [CODE_W-1:0] last_q;
  logic              emit_rst;
  logic              emit_sil;
  logic              emit_st;

  always_comb begin
    emit_rst = pend_rst_q;
    emit_sil = pend_sil_q & ~pend_rst_q;
    emit_st  = ~pend_rst_q & ~pend_sil_q & (cur_code != last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rst_q <= 1'b0;
      pend_sil_q <= 1'b0;
      last_q     <= EC_NONE;
      evt_valid  <= 1'b0;
      evt_code   <= '0;
    end else begin
      pend_rst_q <= reset_req;
      pend_sil_q <= silence_req | (pend_sil_q & ~emit_sil);
      if (reset_req)    last_q <= EC_NONE;
      else if (emit_st) last_q <= cur_code;
      evt_valid <= emit_rst | emit_sil | emit_st;
      if (emit_rst)      evt_code <= EC_RESET;
      else if (emit_sil) evt_code <= EC_SILENCE;
      else if (emit_st)  evt_code <= cur_code;
    end
  end

endmodule

// File: rtl/annun_ctrl.sv
module annun_ctrl
  import annun_pkg::*;
#(
  parameter int PHASE_LEN  = 8,
  parameter int TEST_TICKS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         alarm_in,
  input  logic         fault_in,
  input  logic         trouble_in,
  input  logic         proof_mismatch,
  input  logic         sensing_lost,
  input  logic         test_req,
  input  logic         silence_req,
  input  logic         reset_req,
  output logic         led_pwr,
  output logic         led_alm,
  output logic         led_flt,
  output logic         led_comm,
  output logic         buzzer_en,
  output logic         evt_valid,
  output logic [7:0]   evt_code
);

  localparam int PH_W = $clog2(PHASE_LEN);
  localparam int TT_W = $clog2(TEST_TICKS);

  ann_state_e        state_q, state_next, base_state;
  logic [CODE_W-1:0] code_q, code_next, base_code;
  logic              alarm_latch_q;
  logic              alarm_eff;
  logic              test_q, test_next, test_start, test_done;
  logic [TT_W-1:0]   test_cnt_q;
  logic              silenced_q, silenced_next;
  logic              state_chg;
  led_t              leds;
  logic [PH_W-1:0]   phase;

  assign alarm_eff = alarm_latch_q | alarm_in;

  annun_classify u_cls (
    .sensing_lost   (sensing_lost),
    .proof_mismatch (proof_mismatch),
    .alarm_eff      (alarm_eff),
    .fault_in       (fault_in),
    .trouble_in     (trouble_in),
    .base_state     (base_state),
    .base_code      (base_code)
  );

  always_comb begin
    test_start = test_req & ~test_q & (base_state == ST_NORMAL);
    test_done  = test_q & tick & (test_cnt_q == TT_W'(TEST_TICKS - 1));
    if (reset_req || base_state != ST_NORMAL) test_next = 1'b0;
    else if (test_q)                         test_next = ~test_done;
    else                                     test_next = test_start;

    if (reset_req) begin
      state_next = ST_NORMAL;
      code_next  = EC_OK;
    end else if (test_next) begin
      state_next = ST_TEST;
      code_next  = EC_TEST;
    end else begin
      state_next = base_state;
      code_next  = base_code;
    end

    state_chg = state_next != state_q;
    if (reset_req || state_chg) silenced_next = 1'b0;
    else                        silenced_next = silenced_q | silence_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_NORMAL;
      code_q        <= EC_OK;
      alarm_latch_q <= 1'b0;
      test_q        <= 1'b0;
      test_cnt_q    <= '0;
      silenced_q    <= 1'b0;
    end else begin
      state_q       <= state_next;
      code_q        <= code_next;
      alarm_latch_q <= reset_req ? 1'b0 : alarm_eff;
      test_q        <= test_next;
      silenced_q    <= silenced_next;
      if (test_q && test_next) test_cnt_q <= tick ? test_cnt_q + 1'b1 : test_cnt_q;
      else                     test_cnt_q <= '0;
    end
  end

  annun_pattern #(.PHASE_LEN(PHASE_LEN)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (state_chg | reset_req),
    .state    (state_q),
    .silenced (silenced_q),
    .leds     (leds),
    .buzz     (buzzer_en),
    .phase    (phase)
  );

  assign led_pwr  = leds.pwr;
  assign led_alm  = leds.alm;
  assign led_flt  = leds.flt;
  assign led_comm = leds.comm;

  annun_evlog u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .silence_req (silence_req),
    .reset_req   (reset_req),
    .cur_code    (code_q),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code)
  );

endmodule

// File: rtl/annun_ctrl_chk.sv
module annun_ctrl_chk
  import annun_pkg::*;
#(
  parameter int PHASE_LEN = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reset_req,
  input logic                          sensing_lost,
  input logic                          proof_mismatch,
  input ann_state_e                    state,
  input logic                          silenced,
  input logic [$clog2(PHASE_LEN)-1:0]  phase,
  input logic                          buzzer_en,
  input logic                          led_pwr,
  input logic                          led_alm,
  input logic                          led_flt,
  input logic                          led_comm,
  input logic                          evt_valid,
  input logic [7:0]                    evt_code
);

  localparam int HALF = PHASE_LEN / 2;

  // R2: lost sensing wins over every other condition
  p_fault_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sensing_lost && !reset_req) |=> state == ST_FAULT);

  // R3: alarm holds until reset unless an overriding fault appears
  p_alarm_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALARM && !reset_req && !sensing_lost && !proof_mismatch) |=> state == ST_ALARM);

  // R4: a muted sounder stays silent
  p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    silenced |-> !buzzer_en);

  // R5: sounder only in the first half of a frame
  p_duty_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer_en |-> (32'(phase) < 32'(HALF)));

  // R7: exactly one LED during test
  p_test_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEST) |-> $countones({led_pwr, led_alm, led_flt, led_comm}) == 1);

  // R8: a reset request is logged first, one cycle later
  p_reset_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> ##1 (evt_valid && evt_code == EC_RESET));

  // R9: reset reinitialises to Normal and drops the mute
  p_reset_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (state == ST_NORMAL && !silenced));

endmodule

bind annun_ctrl annun_ctrl_chk #(.PHASE_LEN(PHASE_LEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reset_req      (reset_req),
  .sensing_lost   (sensing_lost),
  .proof_mismatch (proof_mismatch),
  .state          (state_q),
  .silenced       (silenced_q),
  .phase          (phase),
  .buzzer_en      (buzzer_en),
  .led_pwr        (led_pwr),
  .led_alm        (led_alm),
  .led_flt        (led_flt),
  .led_comm       (led_comm),
  .evt_valid      (evt_valid),
  .evt_code       (evt_code)
);

// File: tb/sim_annun_ctrl.sv
module sim_annun_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SN = 0, SA = 1, SF = 2, ST = 3, SX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, alarm_in = 0, fault_in = 0, trouble_in = 0;
  logic proof_mismatch = 0, sensing_lost = 0, test_req = 0;
  logic silence_req = 0, reset_req = 0;
  logic led_pwr, led_alm, led_flt, led_comm, buzzer_en, evt_valid;
  logic [7:0] evt_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  annun_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_in(alarm_in),
    .fault_in(fault_in), .trouble_in(trouble_in), .proof_mismatch(proof_mismatch),
    .sensing_lost(sensing_lost), .test_req(test_req), .silence_req(silence_req),
    .reset_req(reset_req), .led_pwr(led_pwr), .led_alm(led_alm), .led_flt(led_flt),
    .led_comm(led_comm), .buzzer_en(buzzer_en), .evt_valid(evt_valid), .evt_code(evt_code)
  );

  function automatic logic [4:0] outs();
    return {led_pwr, led_alm, led_flt, led_comm, buzzer_en};
  endfunction

  // expected {pwr,alm,flt,comm,buzz} for an 8-phase frame
  function automatic logic [4:0] expo(int s, int ph);
    case (s)
      SA: return {1'b1, ph inside {0, 1, 4, 5}, 1'b0, 1'b1, ph inside {0, 2}};
      SF: return {3'b101, 1'b1, ph < 4};
      ST: return {3'b100, ph < 4, ph == 0};
      SX: begin
        logic [3:0] l;
        if (ph < 2) l = 4'b1000;
        else if (ph < 4) l = 4'b0100;
        else if (ph < 6) l = 4'b0010;
        else l = 4'b0001;
        return {l, ph == 0};
      end
      default: return 5'b10010;
    endcase
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_evt(string req, logic [7:0] code);
    chk(req, {7'd0, evt_valid}, 8'd1);
    if (evt_valid) chk(req, evt_code, code);
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic do_reset_drain();
    reset_req = 1; step(); reset_req = 0;
    step(2);
  endtask

  task automatic t_reset();
    step(3);
    rst_n = 1;
    chk("R1 leds after reset", {3'd0, outs()}, {3'd0, expo(SN, 0)});
    chk("R1 no event in reset", {7'd0, evt_valid}, 8'd0);
    step();
    chk_evt("R1 heartbeat", 8'h00);
    step();
    chk("R8 single event", {7'd0, evt_valid}, 8'd0);
  endtask

  task automatic t_priority();
    trouble_in = 1; step();
    chk("R6 trouble leds", {3'd0, outs()}, {3'd0, expo(ST, 0)});
    step(); chk_evt("R2 trouble code", 8'h30);
    fault_in = 1; step();
    chk("R2 fault over trouble", {3'd0, outs()}, {3'd0, expo(SF, 0)});
    step(); chk_evt("R2 general fault code", 8'h23);
    alarm_in = 1; step();
    chk("R2 alarm over general fault", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    step(); chk_evt("R2 alarm code", 8'h10);
    alarm_in = 0; proof_mismatch = 1; step();
    chk("R2 proof mismatch over alarm", {3'd0, outs()}, {3'd0, expo(SF, 0)});
    step(); chk_evt("R2 proof code", 8'h22);
    sensing_lost = 1; step(2);
    chk_evt("R2 sensing code", 8'h21);
    sensing_lost = 0; proof_mismatch = 0; fault_in = 0; trouble_in = 0; step();
    chk("R3 alarm still latched", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    step(); chk_evt("R3 alarm re-reported", 8'h10);
    reset_req = 1; step(); reset_req = 0;
    chk("R9 reset to normal", {3'd0, outs()}, {3'd0, expo(SN, 0)});
    step(); chk_evt("R8 reset event", 8'h60);
    step(); chk_evt("R9 state re-reported", 8'h00);
  endtask

  task automatic t_reset_held();
    alarm_in = 1; step(2);
    reset_req = 1; step(); reset_req = 0;
    chk("R9 forced normal", {3'd0, outs()}, {3'd0, expo(SN, 0)});
    step();
    chk("R9 held alarm re-enters", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    chk_evt("R8 reset logged", 8'h60);
    step(); chk_evt("R9 alarm re-reported", 8'h10);
    alarm_in = 0; step(3);
    chk("R3 latch after input drops", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    do_reset_drain();
  endtask

  task automatic t_patterns();
    alarm_in = 1; step(); alarm_in = 0;
    for (int p = 1; p <= 8; p++) begin
      pulse_tick();
      chk("R5 R6 alarm frame", {3'd0, outs()}, {3'd0, expo(SA, p % 8)});
    end
    pulse_tick(); pulse_tick();
    sensing_lost = 1; step();
    chk("R5 fault phase restart", {3'd0, outs()}, {3'd0, expo(SF, 0)});
    for (int p = 1; p <= 8; p++) begin
      pulse_tick();
      chk("R5 R6 fault frame", {3'd0, outs()}, {3'd0, expo(SF, p % 8)});
    end
    sensing_lost = 0;
    do_reset_drain();
    trouble_in = 1; step();
    for (int p = 1; p <= 8; p++) begin
      pulse_tick();
      chk("R5 R6 trouble frame", {3'd0, outs()}, {3'd0, expo(ST, p % 8)});
    end
    trouble_in = 0; step(3);
    chk("R6 normal leds", {3'd0, outs()}, {3'd0, expo(SN, 0)});
  endtask

  task automatic t_silence();
    alarm_in = 1; step(); alarm_in = 0;
    step();
    silence_req = 1; step(); silence_req = 0;
    chk("R4 muted leds kept", {3'd0, outs()}, {3'd0, expo(SA, 0) & 5'b11110});
    step(); chk_evt("R8 silence logged", 8'h50);
    for (int p = 1; p <= 8; p++) begin
      pulse_tick();
      chk("R4 mute holds", {3'd0, outs()}, {3'd0, expo(SA, p % 8) & 5'b11110});
    end
    sensing_lost = 1; step();
    chk("R4 new state re-arms", {3'd0, outs()}, {3'd0, expo(SF, 0)});
    sensing_lost = 0;
    do_reset_drain();
  endtask

  task automatic t_collide();
    alarm_in = 1; silence_req = 1; step();
    alarm_in = 0; silence_req = 0;
    chk("R4 silence loses to entry", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    step(); chk_evt("R8 silence first", 8'h50);
    step(); chk_evt("R8 state second", 8'h10);
    alarm_in = 1; reset_req = 1; silence_req = 1; step();
    reset_req = 0; silence_req = 0;
    chk("R9 reset cycle normal", {3'd0, outs()}, {3'd0, expo(SN, 0)});
    step();
    chk("R4 reset beats silence", {3'd0, outs()}, {3'd0, expo(SA, 0)});
    chk_evt("R8 reset first", 8'h60);
    step(); chk_evt("R8 silence next", 8'h50);
    step(); chk_evt("R8 state last", 8'h10);
    alarm_in = 0;
    do_reset_drain();
  endtask

  task automatic t_test();
    test_req = 1; step(); test_req = 0;
    chk("R7 test entry", {3'd0, outs()}, {3'd0, expo(SX, 0)});
    step(); chk_evt("R7 test code", 8'h40);
    for (int k = 1; k <= 15; k++) begin
      pulse_tick();
      chk("R7 test sequence", {3'd0, outs()}, {3'd0, expo(SX, k % 8)});
    end
    pulse_tick();
    chk("R7 test timeout", {3'd0, outs()}, {3'd0, expo(SN, 0)});
    step(); chk_evt("R7 back to normal", 8'h00);
    trouble_in = 1; step();
    test_req = 1; step(); test_req = 0;
    chk("R7 test ignored off normal", {3'd0, outs()}, {3'd0, expo(ST, 0)});
    trouble_in = 0; step(2);
    test_req = 1; step(); test_req = 0;
    trouble_in = 1; step();
    chk("R7 test aborted", {3'd0, outs()}, {3'd0, expo(ST, 0)});
    trouble_in = 0; step(2);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_reset_held();
    t_patterns();
    t_silence();
    t_collide();
    t_test();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule